// File: doc/BRIEF.md
# Motion Threshold Event Counter

This block watches a stream of signed 16-bit motion samples, one per `smp_valid` strobe. It compares each sample with an upper limit and a lower limit. The upper limit is the upper threshold byte times +128 and the lower limit is the lower threshold byte times -128. Two 4-bit counters record how many samples landed above the upper limit and how many landed below the lower limit. A programmable count that must be reached inside a window of sample periods turns those tallies into an "either" event and a "both" event.

Four sticky status flags record events: new data, window expiry, both-event and either-event. Software clears a flag by writing 1 to its bit. The interrupt line goes high when any flag is set whose enable bit is also set. Configuration and readback use a byte-wide register port with a single-cycle write strobe and a combinational read. Reading the count register clears both tallies. In sleep mode the block drops incoming samples.

Top module: `motion_event_counter`

## Requirements
- R1: After reset every readable register returns 0x00 and `irq` is low.
- R2: The stored widths are: mode bit (0x00), rate bit (0x06), two filter bits (0x07), four enable bits (0x09), three required-count bits (0x0A), eight bits for each threshold (0x0B upper, 0x0C lower), and a 10-bit timer (0x0D low byte, 0x0E bits 1:0 high). Unused bits read 0. Writes to 0x02, 0x03 and 0x05 have no effect.
- R3: Each accepted sample is stored and read back little-endian: low byte at 0x02, high byte at 0x03. It also sets status bit 0.
- R4: A sample counts as above when it is strictly greater than upper×128. It counts as below when it is strictly less than −(lower×128).
- R5: Register 0x05 reads {above count in bits 7:4, below count in bits 3:0}. Each count saturates at 15. A read returns the value before the clock edge and clears both counts. An excursion in the same cycle as the read is counted into the cleared value.
- R6: On an accepted sample, with required count N in 1..7, status bit 3 is set when either count is ≥ N, and status bit 2 is set when both counts are ≥ N. With N = 0 neither bit is ever set. Bit 2 is never set without bit 3.
- R7: With a nonzero timer T, the first excursion opens a window. On the T-th accepted sample after the opening one, the window expires: status bit 1 is set and both counts are cleared before that sample is evaluated. That sample may open a new window. With T = 0 no window opens.
- R8: Writing to 0x04 clears every status bit written as 1. If a bit is set and cleared in the same cycle, the set wins.
- R9: `irq` is high exactly when some status bit and its enable bit in 0x09 are both 1.
- R10: With mode bit 1 (sleep), samples are ignored: the stored sample, counts, window and status are unchanged by `smp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 16 | Signed sample value |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the counts at 0x05) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational, 0 when not reading |
| irq | output | 1 | Active-high interrupt |

## Verification
Two kinds of collision can fall in one cycle. In the first, a read of the count register meets a sample that is an excursion. The bench issues the read and the sample together. It expects the read to return the old saturated tally, and a following read to show exactly one count. In the second, a write-1-to-clear of the status register meets a sample that sets the same flag. The bench drives both together and expects the flag to remain set. Window expiry on a sample that is itself an excursion is provoked the same way. The bench expects the timer flag, and a count of one left over from the sample that opened the new window.

// File: rtl/mec_pkg.sv
package mec_pkg;
  localparam int SMP_W     = 16;
  localparam int CNT_W     = 4;
  localparam int TMR_W     = 10;
  localparam int THR_W     = 8;
  localparam int THR_SHIFT = 7;
  localparam int REQ_W     = 3;
  localparam int NSRC      = 4;
  localparam int ADDR_W    = 4;

  localparam logic [ADDR_W-1:0] A_MODE = 4'h0;
  localparam logic [ADDR_W-1:0] A_SLO  = 4'h2;
  localparam logic [ADDR_W-1:0] A_SHI  = 4'h3;
  localparam logic [ADDR_W-1:0] A_STAT = 4'h4;
  localparam logic [ADDR_W-1:0] A_CNT  = 4'h5;
  localparam logic [ADDR_W-1:0] A_RATE = 4'h6;
  localparam logic [ADDR_W-1:0] A_FILT = 4'h7;
  localparam logic [ADDR_W-1:0] A_IEN  = 4'h9;
  localparam logic [ADDR_W-1:0] A_REQ  = 4'hA;
  localparam logic [ADDR_W-1:0] A_THU  = 4'hB;
  localparam logic [ADDR_W-1:0] A_THL  = 4'hC;
  localparam logic [ADDR_W-1:0] A_TLO  = 4'hD;
  localparam logic [ADDR_W-1:0] A_THI  = 4'hE;

  localparam int B_DATA = 0;
  localparam int B_TMR  = 1;
  localparam int B_AND  = 2;
  localparam int B_OR   = 3;
endpackage

// File: rtl/mec_cfg.sv
module mec_cfg
  import mec_pkg::*;
#(
  parameter int TW = TMR_W,
  parameter int RW = REQ_W,
  parameter int HW = THR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              sleep_q,
  output logic              rate_q,
  output logic [1:0]        filt_q,
  output logic [NSRC-1:0]   ien_q,
  output logic [RW-1:0]     req_q,
  output logic [HW-1:0]     thu_q,
  output logic [HW-1:0]     thl_q,
  output logic [TW-1:0]     tmr_q
);
  logic            sleep_n, rate_n;
  logic [1:0]      filt_n;
  logic [NSRC-1:0] ien_n;
  logic [RW-1:0]   req_n;
  logic [HW-1:0]   thu_n, thl_n;
  logic [TW-1:0]   tmr_n;

  always_comb begin
    sleep_n = sleep_q;
    rate_n  = rate_q;
    filt_n  = filt_q;
    ien_n   = ien_q;
    req_n   = req_q;
    thu_n   = thu_q;
    thl_n   = thl_q;
    tmr_n   = tmr_q;
    if (wr) begin
      case (addr)
        A_MODE: sleep_n = wdata[0];
        A_RATE: rate_n  = wdata[0];
        A_FILT: filt_n  = wdata[1:0];
        A_IEN:  ien_n   = wdata[NSRC-1:0];
        A_REQ:  req_n   = wdata[RW-1:0];
        A_THU:  thu_n   = wdata[HW-1:0];
        A_THL:  thl_n   = wdata[HW-1:0];
        A_TLO:  tmr_n[7:0]    = wdata;
        A_THI:  tmr_n[TW-1:8] = wdata[TW-9:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= 1'b0;
      rate_q  <= 1'b0;
      filt_q  <= '0;
      ien_q   <= '0;
      req_q   <= '0;
      thu_q   <= '0;
      thl_q   <= '0;
      tmr_q   <= '0;
    end else begin
      sleep_q <= sleep_n;
      rate_q  <= rate_n;
      filt_q  <= filt_n;
      ien_q   <= ien_n;
      req_q   <= req_n;
      thu_q   <= thu_n;
      thl_q   <= thl_n;
      tmr_q   <= tmr_n;
    end
  end
endmodule

// File: rtl/mec_window.sv
module mec_window
  import mec_pkg::*;
#(
  parameter int SW = SMP_W,
  parameter int CW = CNT_W,
  parameter int TW = TMR_W,
  parameter int HW = THR_W,
  parameter int HS = THR_SHIFT,
  parameter int RW = REQ_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic [SW-1:0] sample,
  input  logic [HW-1:0] thu,
  input  logic [HW-1:0] thl,
  input  logic [TW-1:0] tmr,
  input  logic [RW-1:0] req,
  input  logic          cnt_clr,
  output logic [CW-1:0] up_q,
  output logic [CW-1:0] lo_q,
  output logic          evt_tmr,
  output logic          evt_and,
  output logic          evt_or
);
  localparam int CMPW = SW + 2;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic signed [CMPW-1:0] s_ext, up_lim, lo_lim;
  logic                   above, below, expire;
  logic [CW-1:0]          up_b, lo_b, up_n, lo_n, req_x;
  logic                   run_q, run_n;
  logic [TW-1:0]          left_q, left_n;

  assign s_ext  = {{2{sample[SW-1]}}, sample};
  assign up_lim = {{(CMPW-HW-HS){1'b0}}, thu, {HS{1'b0}}};
  assign lo_lim = -$signed({{(CMPW-HW-HS){1'b0}}, thl, {HS{1'b0}}});
  assign above  = s_ext > up_lim;
  assign below  = s_ext < lo_lim;
  assign req_x  = {{(CW-RW){1'b0}}, req};

  always_comb begin
    expire = acc && run_q && (left_q == TW'(1));
    up_b   = (cnt_clr || expire) ? '0 : up_q;
    lo_b   = (cnt_clr || expire) ? '0 : lo_q;
    up_n   = (acc && above && up_b != CMAX) ? up_b + CW'(1) : up_b;
    lo_n   = (acc && below && lo_b != CMAX) ? lo_b + CW'(1) : lo_b;
    run_n  = run_q;
    left_n = left_q;
    if (acc) begin
      if (expire || !run_q) begin
        run_n  = (above || below) && (tmr != '0);
        left_n = tmr;
      end else begin
        left_n = left_q - TW'(1);
      end
    end
    evt_tmr = expire;
    evt_or  = acc && (req != '0) && ((up_n >= req_x) || (lo_n >= req_x));
    evt_and = acc && (req != '0) && (up_n >= req_x) && (lo_n >= req_x);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q   <= '0;
      lo_q   <= '0;
      run_q  <= 1'b0;
      left_q <= '0;
    end else begin
      up_q   <= up_n;
      lo_q   <= lo_n;
      run_q  <= run_n;
      left_q <= left_n;
    end
  end
endmodule

// File: rtl/mec_status.sv
module mec_status
  import mec_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] ien,
  output logic [N-1:0] st_q,
  output logic         irq
);
  logic [N-1:0] st_n;

  always_comb st_n = (st_q & ~clr) | set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_n;
  end

  assign irq = |(st_q & ien);
endmodule

// File: rtl/motion_event_counter.sv
module motion_event_counter
  import mec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_data,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq
);
  logic              sleep_q, rate_q;
  logic [1:0]        filt_q;
  logic [NSRC-1:0]   ien_q, st_q, st_set, st_clr;
  logic [REQ_W-1:0]  req_q;
  logic [THR_W-1:0]  thu_q, thl_q;
  logic [TMR_W-1:0]  tmr_q;
  logic [CNT_W-1:0]  up_cnt, lo_cnt;
  logic [2*CNT_W-1:0] cnt_byte;
  logic [SMP_W-1:0]  smp_q, smp_n;
  logic              acc, cnt_rd, evt_tmr, evt_and, evt_or;

  assign acc      = smp_valid && !sleep_q;
  assign cnt_rd   = reg_rd && (reg_addr == A_CNT);
  assign cnt_byte = {up_cnt, lo_cnt};

  mec_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .sleep_q(sleep_q), .rate_q(rate_q), .filt_q(filt_q), .ien_q(ien_q),
    .req_q(req_q), .thu_q(thu_q), .thl_q(thl_q), .tmr_q(tmr_q)
  );

  mec_window u_win (
    .clk(clk), .rst_n(rst_n), .acc(acc), .sample(smp_data),
    .thu(thu_q), .thl(thl_q), .tmr(tmr_q), .req(req_q), .cnt_clr(cnt_rd),
    .up_q(up_cnt), .lo_q(lo_cnt),
    .evt_tmr(evt_tmr), .evt_and(evt_and), .evt_or(evt_or)
  );

  always_comb begin
    st_set         = '0;
    st_set[B_DATA] = acc;
    st_set[B_TMR]  = evt_tmr;
    st_set[B_AND]  = evt_and;
    st_set[B_OR]   = evt_or;
    st_clr = (reg_wr && reg_addr == A_STAT) ? reg_wdata[NSRC-1:0] : '0;
  end

  mec_status u_st (
    .clk(clk), .rst_n(rst_n), .set(st_set), .clr(st_clr), .ien(ien_q),
    .st_q(st_q), .irq(irq)
  );

  always_comb smp_n = acc ? smp_data : smp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_q <= '0;
    else        smp_q <= smp_n;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        A_MODE: reg_rdata = {7'b0, sleep_q};
        A_SLO:  reg_rdata = smp_q[7:0];
        A_SHI:  reg_rdata = smp_q[SMP_W-1:8];
        A_STAT: reg_rdata = {{(8-NSRC){1'b0}}, st_q};
        A_CNT:  reg_rdata = cnt_byte;
        A_RATE: reg_rdata = {7'b0, rate_q};
        A_FILT: reg_rdata = {6'b0, filt_q};
        A_IEN:  reg_rdata = {{(8-NSRC){1'b0}}, ien_q};
        A_REQ:  reg_rdata = {{(8-REQ_W){1'b0}}, req_q};
        A_THU:  reg_rdata = thu_q;
        A_THL:  reg_rdata = thl_q;
        A_TLO:  reg_rdata = tmr_q[7:0];
        A_THI:  reg_rdata = {{(16-TMR_W){1'b0}}, tmr_q[TMR_W-1:8]};
        default: reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/mec_checker.sv
module mec_checker
  import mec_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              wclr_tmr,
  input logic              irq,
  input logic [NSRC-1:0]   st,
  input logic [NSRC-1:0]   ien,
  input logic              sleep,
  input logic [REQ_W-1:0]  req,
  input logic [2*CNT_W-1:0] cnt
);
  AST_AND_WITH_OR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st[B_AND]) |-> st[B_OR]);  // R6
  AST_REQ_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0 && !st[B_OR] && !st[B_AND]) |=> (!st[B_OR] && !st[B_AND]));  // R6
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !(reg_rd && reg_addr == A_CNT)) |=> $stable(cnt));  // R10
  AST_DATA_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !sleep) |=> st[B_DATA]);  // R3
  AST_W1C_TMR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_STAT && wclr_tmr && !smp_valid) |=> !st[B_TMR]);  // R8
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);  // R9
  AST_CNT_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_CNT && (!smp_valid || sleep)) |=> (cnt == '0));  // R5
endmodule

bind motion_event_counter mec_checker u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .reg_rd(reg_rd),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .wclr_tmr(reg_wdata[1]), .irq(irq),
  .st(st_q), .ien(ien_q), .sleep(sleep_q), .req(req_q), .cnt(cnt_byte)
);

// File: tb/tb_motion_event_counter.sv
module tb_motion_event_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_data = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] last_rd;

  // behavioural reference state
  int m_sleep, m_rate, m_filt, m_en, m_req, m_thu, m_thl, m_tmr;
  int m_st, m_up, m_lo, m_run, m_left, m_smp;

  always #5 clk = ~clk;

  motion_event_counter dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_sleep = 0; m_rate = 0; m_filt = 0; m_en = 0; m_req = 0; m_thu = 0;
    m_thl = 0; m_tmr = 0; m_st = 0; m_up = 0; m_lo = 0; m_run = 0;
    m_left = 0; m_smp = 0;
  endtask

  function automatic int exp_rd(input int a);
    case (a)
      0:  return m_sleep;
      2:  return m_smp & 255;
      3:  return (m_smp >> 8) & 255;
      4:  return m_st;
      5:  return m_up * 16 + m_lo;
      6:  return m_rate;
      7:  return m_filt;
      9:  return m_en;
      10: return m_req;
      11: return m_thu;
      12: return m_thl;
      13: return m_tmr & 255;
      14: return m_tmr >> 8;
      default: return 0;
    endcase
  endfunction

  task automatic model_step(input bit wr, input bit rd, input int a, input int d,
                            input bit sv, input logic [15:0] sd);
    int  s, u, l, setb, clrb;
    bit  acc, ab, be, ex;
    acc = sv && (m_sleep == 0);
    s   = int'($signed(sd));
    ab  = s > m_thu * 128;
    be  = s < -(m_thl * 128);
    ex  = acc && m_run != 0 && m_left == 1;
    u = ((rd && a == 5) || ex) ? 0 : m_up;
    l = ((rd && a == 5) || ex) ? 0 : m_lo;
    if (acc && ab && u < 15) u++;
    if (acc && be && l < 15) l++;
    setb = 0;
    if (acc) setb |= 1;
    if (ex)  setb |= 2;
    if (acc && m_req != 0 && u >= m_req && l >= m_req) setb |= 4;
    if (acc && m_req != 0 && (u >= m_req || l >= m_req)) setb |= 8;
    if (acc) begin
      if (ex || m_run == 0) begin
        m_run  = ((ab || be) && m_tmr != 0) ? 1 : 0;
        m_left = m_tmr;
      end else m_left = m_left - 1;
    end
    clrb = (wr && a == 4) ? (d & 15) : 0;
    m_st = (m_st & ~clrb) | setb;
    m_up = u; m_lo = l;
    if (acc) m_smp = int'(sd);
    if (wr) begin
      case (a)
        0:  m_sleep = d & 1;
        6:  m_rate = d & 1;
        7:  m_filt = d & 3;
        9:  m_en = d & 15;
        10: m_req = d & 7;
        11: m_thu = d;
        12: m_thl = d;
        13: m_tmr = (m_tmr & 768) | d;
        14: m_tmr = (m_tmr & 255) | ((d & 3) << 8);
        default: ;
      endcase
    end
  endtask

  // one clock: drive, compare against reference, then advance reference
  task automatic cyc(input bit wr, input bit rd, input int a, input int d,
                     input bit sv, input logic [15:0] sd, input string tag);
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_addr = 4'(a); reg_wdata = 8'(d);
    smp_valid = sv; smp_data = sd;
    #1;
    chk(irq == ((m_st & m_en) != 0), "R9 irq vs reference", int'(irq),
        int'((m_st & m_en) != 0));
    if (rd) begin
      last_rd = reg_rdata;
      chk(int'(reg_rdata) == exp_rd(a), tag, int'(reg_rdata), exp_rd(a));
    end
    @(posedge clk);
    model_step(wr, rd, a, d, sv, sd);
    #1;
    reg_wr = 0; reg_rd = 0; smp_valid = 0;
  endtask

  task automatic wreg(input int a, input int d);
    cyc(1, 0, a, d, 0, '0, "write");
  endtask
  task automatic rreg(input int a, input string tag);
    cyc(0, 1, a, 0, 0, '0, tag);
  endtask
  task automatic rlit(input int a, input int e, input string tag);
    cyc(0, 1, a, 0, 0, '0, tag);
    chk(int'(last_rd) == e, tag, int'(last_rd), e);
  endtask
  task automatic smp(input logic [15:0] v);
    cyc(0, 0, 0, 0, 1, v, "sample");
  endtask
  task automatic irq_lit(input bit e, input string tag);
    @(negedge clk);
    chk(irq == e, tag, int'(irq), int'(e));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    irq_lit(1'b0, "R1 irq after reset");
    for (int a = 0; a < 15; a++) rlit(a, 0, "R1 register reset value");

    // R2: field widths and read-only addresses
    wreg(10, 8'hFF); rlit(10, 8'h07, "R2 required count width");
    wreg(14, 8'hFF); rlit(14, 8'h03, "R2 timer high width");
    wreg(13, 8'h34); rlit(13, 8'h34, "R2 timer low");
    wreg(7, 8'hFF);  rlit(7, 8'h03, "R2 filter width");
    wreg(9, 8'hFF);  rlit(9, 8'h0F, "R2 enable width");
    wreg(6, 8'hFF);  rlit(6, 8'h01, "R2 rate width");
    wreg(11, 8'h80); rlit(11, 8'h80, "R2 upper threshold");
    wreg(5, 8'hAA);  rlit(5, 8'h00, "R2 count is read-only");
    wreg(2, 8'h55);  rlit(2, 8'h00, "R2 sample is read-only");
    wreg(10, 0); wreg(13, 0); wreg(14, 0); wreg(9, 0); wreg(11, 0);

    // R3: sample storage
    smp(16'h1234);
    rlit(2, 8'h34, "R3 sample low byte");
    rlit(3, 8'h12, "R3 sample high byte");
    rlit(4, 8'h01, "R3 data flag");
    wreg(4, 8'h01); rlit(4, 8'h00, "R8 status cleared");
    rreg(5, "R5 count read");

    // R4: strict threshold compare
    wreg(11, 2); wreg(12, 1);
    smp(16'd256); smp(16'd257); smp(-16'sd128); smp(-16'sd129);
    rlit(5, 8'h11, "R4 strict compare counts");
    rlit(5, 8'h00, "R5 read clears");

    // R5: saturation and read with simultaneous excursion
    for (int i = 0; i < 20; i++) smp(16'd1000);
    cyc(0, 1, 5, 0, 1, 16'd1000, "R5 read during excursion");
    chk(last_rd == 8'hF0, "R5 saturated value", int'(last_rd), 8'hF0);
    rlit(5, 8'h10, "R5 excursion kept after clear");

    // R6: either/both events
    wreg(10, 3); wreg(9, 8'h0C); wreg(4, 8'h0F);
    smp(16'd1000); smp(16'd1000);
    rlit(4, 8'h01, "R6 below required count");
    irq_lit(1'b0, "R9 no enabled flag");
    smp(16'd1000);
    rlit(4, 8'h09, "R6 either event");
    irq_lit(1'b1, "R9 either enabled");
    smp(-16'sd1000); smp(-16'sd1000); smp(-16'sd1000);
    rlit(4, 8'h0D, "R6 both event");
    rreg(5, "R5 count read"); wreg(4, 8'h0F);
    wreg(10, 0);
    for (int i = 0; i < 4; i++) smp(16'd1000);
    rlit(4, 8'h01, "R6 zero required count");
    rreg(5, "R5 count read");

    // R7: window timer
    wreg(10, 7); wreg(13, 3); wreg(4, 8'h0F);
    smp(16'd1000); smp(16'd0); smp(16'd0);
    rlit(4, 8'h01, "R7 window still open");
    smp(16'd0);
    rlit(4, 8'h03, "R7 expiry flag");
    rlit(5, 8'h00, "R7 expiry clears counts");
    smp(16'd1000); smp(16'd0); smp(16'd0); smp(16'd1000);
    rlit(5, 8'h10, "R7 expiry on excursion reopens");
    wreg(13, 0);
    smp(16'd0); smp(16'd0); smp(16'd0);
    rreg(4, "R7 status after close");

    // R8: set wins over clear
    wreg(4, 8'h0F); rlit(4, 8'h00, "R8 clear all");
    cyc(1, 0, 4, 8'h01, 1, 16'd0, "R8 clear with sample");
    rlit(4, 8'h01, "R8 set wins");

    // R9: enable masking
    wreg(9, 8'h01); irq_lit(1'b1, "R9 data enabled");
    wreg(9, 8'h00); irq_lit(1'b0, "R9 all masked");

    // R10: sleep
    rreg(5, "R5 count read");
    smp(16'd1000);
    wreg(0, 1); wreg(4, 8'h0F);
    smp(16'd1000); smp(16'd1000); smp(-16'sd1000); smp(16'd7);
    rlit(5, 8'h10, "R10 counts hold");
    rlit(2, 8'hE8, "R10 sample not stored");
    rlit(4, 8'h00, "R10 no status");
    wreg(0, 0); smp(16'd5);
    rlit(4, 8'h01, "R10 awake again");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule